// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is an 8-bit general-purpose I/O port behind a small register bus. The bus has an address, a write strobe, a read strobe, write data and read data. Three registers sit at consecutive byte addresses from a base address:

- a direction register that can only be written,
- an output data register that can be read and written,
- a pin-state view that can only be read.

Each pin gets an output enable and an output value. The enable follows its direction bit and the value follows its output data bit.

Pin inputs pass through a two-flop synchronizer before any read can see them. A read of the pin-state address is built bit by bit. Where the direction bit is 1 it returns the stored output data bit. Where the direction bit is 0 it returns the synchronized pin level.

Two standby inputs control the registers:

- Hardware standby clears both registers and forces every output enable low while it is held.
- Software standby freezes both registers. Bus writes are ignored while it is held.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the direction and output data registers are 0x00, so every pin_oe and pin_out bit is 0.
- R2: A write to offset 0 (direction) sets pin_oe to the written value on the clock edge where bus_wr is high. A write to offset 1 (output data) sets pin_out the same way. A 1 in a direction bit makes that pin an output.
- R3: A read of offset 0 never returns the direction contents. It returns the fixed filler value 0xFF.
- R4: A read of offset 1 returns the last value written to the output data register.
- R5: A read of offset 2 returns, for each bit i, the output data bit i when direction bit i is 1, and the synchronized pin_in bit i when direction bit i is 0.
- R6: A write to offset 2 changes neither the direction register nor the output data register.
- R7: While hw_stby is 1, every pin_oe bit is 0 in the same cycle. Both registers are cleared to 0x00 at the next clock edge. Writes during hw_stby are discarded.
- R8: While sw_stby is 1 and hw_stby is 0, writes are ignored and both registers keep their values.
- R9: A change on pin_in shows up in an offset-2 read (input bits) after exactly two rising clock edges, and not after one.
- R10: bus_rdata is 0x00 when bus_rd is 0, and for reads of any address other than offsets 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: clears registers, disables outputs |
| sw_stby | input | 1 | Software standby: freezes registers, blocks writes |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational during bus_rd |
| pin_in | input | 8 | Pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The hardest case to reach from the ports is a pin-state read that mixes sources. It only shows up when direction, output data and pin level all differ in the same bits, and only once the synchronizer has settled.

The bench sweeps all 256 direction values. For each one it drives output data and pin levels that complement each other, so a wrong source on any bit changes the result.

It also steps a pin change one edge at a time to pin the two-cycle latency down. It holds each standby input across attempted writes, then reads back through the bus and the pin outputs to confirm which registers survived.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_OUT  = 2'd2,
      SEL_PIN  = 2'd3
   } reg_sel_e;

   localparam int unsigned OFS_DIR = 0;
   localparam int unsigned OFS_OUT = 1;
   localparam int unsigned OFS_PIN = 2;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_port_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned BASE_ADDR = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE_ADDR + OFS_DIR);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(BASE_ADDR + OFS_OUT);
   localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(BASE_ADDR + OFS_PIN);

   generate
      if (BASE_ADDR + OFS_PIN >= (1 << ADDR_W)) begin : g_bad_base
         $error("gpio_addr_dec: register window exceeds address space");
      end
   endgenerate

   always_comb begin
      if (addr == A_DIR)      sel = SEL_DIR;
      else if (addr == A_OUT) sel = SEL_OUT;
      else if (addr == A_PIN) sel = SEL_PIN;
      else                    sel = SEL_NONE;
   end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regfile.sv
module gpio_port_regfile
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic             wr_en,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] out_q
);
   logic wr_ok;
   assign wr_ok = wr_en && !sw_stby;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
      end else if (hw_stby) begin
         dir_q <= '0;
         out_q <= '0;
      end else if (wr_ok) begin
         if (sel == SEL_DIR) dir_q <= wdata;
         if (sel == SEL_OUT) out_q <= wdata;
      end
   end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_port_pkg::*;
#(
   parameter int unsigned    WIDTH    = 8,
   parameter logic [WIDTH-1:0] DIR_FILL = '1
) (
   input  logic             rd_en,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] out_q,
   input  logic [WIDTH-1:0] pin_sync,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] pin_view;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign pin_view[b] = dir_q[b] ? out_q[b] : pin_sync[b];
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (sel)
            SEL_DIR: rdata = DIR_FILL;
            SEL_OUT: rdata = out_q;
            SEL_PIN: rdata = pin_view;
            default: rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned      WIDTH       = 8,
   parameter int unsigned      ADDR_W      = 4,
   parameter int unsigned      BASE_ADDR   = 0,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] DIR_FILL    = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_out
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gpio_port_regs: WIDTH must be positive");
      end
   endgenerate

   reg_sel_e         sel;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] out_q;
   logic [WIDTH-1:0] pin_sync;

   gpio_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpio_port_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_stby (hw_stby),
      .sw_stby (sw_stby),
      .wr_en   (bus_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .dir_q   (dir_q),
      .out_q   (out_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   gpio_read_mux #(.WIDTH(WIDTH), .DIR_FILL(DIR_FILL)) u_rmux (
      .rd_en    (bus_rd),
      .sel      (sel),
      .dir_q    (dir_q),
      .out_q    (out_q),
      .pin_sync (pin_sync),
      .rdata    (bus_rdata)
   );

   assign pin_oe  = hw_stby ? '0 : dir_q;
   assign pin_out = out_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned      WIDTH     = 8,
   parameter int unsigned      ADDR_W    = 4,
   parameter int unsigned      BASE_ADDR = 0,
   parameter logic [WIDTH-1:0] DIR_FILL  = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_stby,
   input logic              sw_stby,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pin_out
);
   localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(BASE_ADDR + 2);

   // R2: a permitted write to the output data register reaches pin_out
   a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_OUT && !sw_stby && !hw_stby)
         |=> pin_out == $past(bus_wdata));

   // R2: a permitted write to the direction register reaches pin_oe
   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DIR && !sw_stby && !hw_stby)
         |=> (hw_stby || pin_oe == $past(bus_wdata)));

   // R3: reads of the direction address return the filler value
   a_r3_dir_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_DIR) |-> bus_rdata == DIR_FILL);

   // R4: reads of the output data address match the driven output value
   a_r4_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_OUT) |-> bus_rdata == pin_out);

   // R6: writes to the pin-state address leave the output data unchanged
   a_r6_pin_wr_noeffect: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_PIN && !hw_stby) |=> $stable(pin_out));

   // R7: hardware standby clears the output data register
   a_r7_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> pin_out == '0);

   // R8: software standby holds the output data register
   a_r8_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_stby && !hw_stby) |=> $stable(pin_out));

   // R10: the read bus is idle without a read strobe
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);
endmodule

bind gpio_port_regs gpio_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DIR_FILL(DIR_FILL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hw_stby   (hw_stby),
   .sw_stby   (sw_stby),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_oe    (pin_oe),
   .pin_out   (pin_out)
);

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_stby = 1'b0;
   logic       sw_stby = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe;
   logic [7:0] pin_out;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   gpio_port_regs dut_i (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] r;
      logic [7:0] expv;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 oe", pin_oe, 8'h00);
      check("R1 out", pin_out, 8'h00);
      rst_n = 1'b1;
      rd(4'd1, r); check("R1 out read", r, 8'h00);
      // R10 idle read bus and unmapped addresses
      #1 check("R10 idle", bus_rdata, 8'h00);
      for (int a = 3; a < 16; a++) begin
         rd(4'(a), r); check("R10 unmapped", r, 8'h00);
      end
      // R2/R4 sweep output data; R3 filler on every direction value
      for (int v = 0; v < 256; v++) begin
         wr(4'd1, 8'(v));
         check("R2 pin_out", pin_out, 8'(v));
         rd(4'd1, r); check("R4 readback", r, 8'(v));
         wr(4'd0, 8'(v));
         check("R2 pin_oe", pin_oe, 8'(v));
         rd(4'd0, r); check("R3 fill", r, 8'hFF);
      end
      // R5 mixed read sweep over all direction values
      for (int d = 0; d < 256; d++) begin
         logic [7:0] ov;
         logic [7:0] pv;
         ov = 8'(d * 37 + 5);
         pv = ~ov;
         wr(4'd0, 8'(d));
         wr(4'd1, ov);
         @(negedge clk); pin_in = pv;
         repeat (2) @(negedge clk);
         rd(4'd2, r);
         expv = (8'(d) & ov) | (~8'(d) & pv);
         check("R5 mix", r, expv);
      end
      // R6 writes to pin-state address ignored
      wr(4'd0, 8'h3C); wr(4'd1, 8'h96);
      wr(4'd2, 8'h41);
      check("R6 oe kept", pin_oe, 8'h3C);
      rd(4'd1, r); check("R6 out kept", r, 8'h96);
      // R9 synchronizer latency
      wr(4'd0, 8'h00);
      @(negedge clk); pin_in = 8'h00;
      repeat (3) @(negedge clk);
      pin_in = 8'hA5;
      @(negedge clk);
      bus_addr = 4'd2; bus_rd = 1'b1;
      #1 check("R9 one edge", bus_rdata, 8'h00);
      @(negedge clk);
      #1 check("R9 two edges", bus_rdata, 8'hA5);
      bus_rd = 1'b0;
      // R8 software standby
      wr(4'd0, 8'hF0); wr(4'd1, 8'h5A);
      @(negedge clk); sw_stby = 1'b1;
      wr(4'd0, 8'h0F); wr(4'd1, 8'hC3);
      check("R8 oe held", pin_oe, 8'hF0);
      rd(4'd1, r); check("R8 out held", r, 8'h5A);
      @(negedge clk); sw_stby = 1'b0;
      wr(4'd1, 8'hC3);
      check("R8 write after", pin_out, 8'hC3);
      // R7 hardware standby
      wr(4'd0, 8'hFF); wr(4'd1, 8'hA5);
      @(negedge clk); hw_stby = 1'b1;
      #1 check("R7 oe low now", pin_oe, 8'h00);
      @(negedge clk);
      check("R7 out cleared", pin_out, 8'h00);
      wr(4'd1, 8'h77);
      check("R7 write dropped", pin_out, 8'h00);
      @(negedge clk); hw_stby = 1'b0;
      #1 check("R7 dir cleared", pin_oe, 8'h00);
      rd(4'd1, r); check("R7 out read", r, 8'h00);
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule